// File: doc/BRIEF.md
# I2C Bus Unjam Sequencer

This block frees an I2C bus that a target has left holding SDA low, typically after a transfer was cut short partway through a byte. The block takes the SCL and SDA pins away from the normal I2C controller and drives them open-drain itself. It forms a start condition, then clocks nine SCL pulses with SDA left released, and then forms a stop condition. A target that is stuck mid-byte sees enough clocks to finish shifting and to let go of SDA. The stop condition then returns it to idle.

When the pattern is complete, the pins go back to the controller and the controller receives a one-cycle reset pulse. After one more delay interval, the block checks the synchronized line levels together with the controller's busy flag. It reports pass or fail with a one-cycle done pulse. Each step of the pattern lasts a programmable number of system clocks. Between recoveries the block continuously reports whether the bus is available. Firmware or a supervisor uses that flag to decide when to issue a recover request. Detecting a stuck bus automatically is not part of this block.

Top module: `i2c_bus_unjam`

## Requirements
- R1: `avail_o` is 1 exactly when `bus_busy_i` is 0 and the SCL and SDA levels, delayed by a two-flop synchronizer, are both 1. A change on a line input therefore reaches `avail_o` within three clock edges.
- R2: Outside a recovery, `pin_own_o`, `scl_pull_o`, `sda_pull_o`, `ctrl_rst_o` and `done_o` are all 0. A pull output is 1 only while `pin_own_o` is 1. A pull output of 1 means the line is driven low, and 0 means the line is released.
- R3: A recovery begins on the clock edge that samples `recover_i` high while the block is idle. Both lines are released for the first interval. SDA is then pulled low while SCL stays released, which forms exactly one start condition.
- R4: Between the start and the stop, SCL is pulled low and released again nine times, and SDA is released during each SCL-high phase. Counting the stop, SCL therefore goes from pulled to released exactly 10 times during a recovery.
- R5: The last line event during ownership is exactly one stop condition: SDA goes from pulled to released while SCL is released. It follows the 10th SCL release.
- R6: Every step lasts max(`half_period_i`, 1) clocks. `pin_own_o` is therefore high for exactly 24 × max(`half_period_i`, 1) consecutive cycles.
- R7: `ctrl_rst_o` is high for exactly one cycle, which is the first cycle after `pin_own_o` falls. It is never high while `pin_own_o` is high.
- R8: `done_o` is high for exactly one cycle, max(`half_period_i`, 1) + 1 cycles after `ctrl_rst_o`. In the same cycle, `fail_o` takes the inverse of `avail_o`, and it holds that value until the next recovery starts, when it clears to 0.
- R9: A `recover_i` pulse that arrives while a recovery is running is ignored. The ownership length and the single done pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| recover_i | input | 1 | Request to start a recovery |
| half_period_i | input | DLY_W | Length of each step in clocks; 0 is treated as 1 |
| bus_busy_i | input | 1 | Busy flag from the I2C controller |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_pull_o | output | 1 | Pull SCL low (open-drain enable) |
| sda_pull_o | output | 1 | Pull SDA low (open-drain enable) |
| pin_own_o | output | 1 | 1: this block drives the pins; 0: the controller owns them |
| ctrl_rst_o | output | 1 | One-cycle reset pulse to the controller |
| done_o | output | 1 | One-cycle pulse when the final check is made |
| fail_o | output | 1 | Bus still unavailable at the last final check |
| avail_o | output | 1 | Bus is not busy and both lines are high |

## Verification
The recovery is run with step lengths of 3, 1, 0 and 5 clocks. These runs separate correct per-step counting from an off-by-one error, and they show that a zero setting is clamped to one clock rather than wrapping. One run keeps a target model holding SDA low until the second SCL release, which shows that the clocking actually frees the bus and that `fail_o` stays 0. Another run holds SDA low permanently, which must end with `fail_o` set. A third run sends a second request in the middle of a recovery, which tells a request that is correctly ignored from one that restarts or extends the pattern. Separate tests of the availability flag drive the busy flag and each line on its own, which shows that the synchronizer delay is applied and that all three terms are present.

// File: rtl/i2c_unjam_pkg.sv
package i2c_unjam_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_START_SDA,
    ST_START_SCL,
    ST_CLK_HI,
    ST_CLK_LO,
    ST_TAIL,
    ST_STOP_SCL,
    ST_STOP_SDA,
    ST_HANDBACK,
    ST_SETTLE,
    ST_CHECK
  } unjam_state_e;
endpackage

// File: rtl/i2c_unjam_sync.sv
module i2c_unjam_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[g] <= '1;
        else if (g == 0) pipe_q[g] <= d_i;
        else pipe_q[g] <= pipe_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_unjam_timer.sv
module i2c_unjam_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [DLY_W-1:0] limit_i,
  output logic             expire_o
);
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] last;

  // zero limit behaves as one clock per step
  assign last     = (limit_i == '0) ? '0 : limit_i - 1'b1;
  assign expire_o = !hold_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (hold_i || expire_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_unjam_fsm.sv
module i2c_unjam_fsm
  import i2c_unjam_pkg::*;
#(
  parameter int NUM_PULSES = 9,
  localparam int PC_W = $clog2(NUM_PULSES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic recover_i,
  input  logic step_done_i,
  input  logic avail_i,
  output logic timer_hold_o,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic pin_own_o,
  output logic ctrl_rst_o,
  output logic done_o,
  output logic fail_o
);
  unjam_state_e state_q, state_d;
  logic [PC_W-1:0] pulse_q;
  logic fail_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (recover_i) state_d = ST_PRE;
      ST_PRE:       if (step_done_i) state_d = ST_START_SDA;
      ST_START_SDA: if (step_done_i) state_d = ST_START_SCL;
      ST_START_SCL: if (step_done_i) state_d = ST_CLK_HI;
      ST_CLK_HI:    if (step_done_i) state_d = ST_CLK_LO;
      ST_CLK_LO:
        if (step_done_i)
          state_d = (pulse_q == PC_W'(NUM_PULSES - 1)) ? ST_TAIL : ST_CLK_HI;
      ST_TAIL:      if (step_done_i) state_d = ST_STOP_SCL;
      ST_STOP_SCL:  if (step_done_i) state_d = ST_STOP_SDA;
      ST_STOP_SDA:  if (step_done_i) state_d = ST_HANDBACK;
      ST_HANDBACK:  state_d = ST_SETTLE;
      ST_SETTLE:    if (step_done_i) state_d = ST_CHECK;
      ST_CHECK:     state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pulse_q <= '0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && recover_i) begin
        pulse_q <= '0;
        fail_q  <= 1'b0;
      end
      if (state_q == ST_CLK_LO && step_done_i) pulse_q <= pulse_q + 1'b1;
      if (state_q == ST_CHECK) fail_q <= !avail_i;
    end
  end

  always_comb begin
    scl_pull_o = 1'b0;
    sda_pull_o = 1'b0;
    unique case (state_q)
      ST_START_SDA: sda_pull_o = 1'b1;
      ST_START_SCL, ST_TAIL: begin scl_pull_o = 1'b1; sda_pull_o = 1'b1; end
      ST_CLK_LO:    scl_pull_o = 1'b1;
      ST_STOP_SCL:  sda_pull_o = 1'b1;
      default: ;
    endcase
  end

  assign pin_own_o    = !(state_q inside {ST_IDLE, ST_HANDBACK, ST_SETTLE, ST_CHECK});
  assign timer_hold_o = state_q inside {ST_IDLE, ST_HANDBACK, ST_CHECK};
  assign ctrl_rst_o   = (state_q == ST_HANDBACK);
  assign done_o       = (state_q == ST_CHECK);
  assign fail_o       = fail_q;
endmodule

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam #(
  parameter int DLY_W      = 16,
  parameter int NUM_PULSES = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             recover_i,
  input  logic [DLY_W-1:0] half_period_i,
  input  logic             bus_busy_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_pull_o,
  output logic             sda_pull_o,
  output logic             pin_own_o,
  output logic             ctrl_rst_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             avail_o
);
  logic [1:0] lines_s;
  logic       step_done, timer_hold;

  i2c_unjam_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sda_i, scl_i}),
    .q_o   (lines_s)
  );

  assign avail_o = !bus_busy_i && (&lines_s);

  i2c_unjam_timer #(.DLY_W(DLY_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (timer_hold),
    .limit_i (half_period_i),
    .expire_o(step_done)
  );

  i2c_unjam_fsm #(.NUM_PULSES(NUM_PULSES)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .recover_i   (recover_i),
    .step_done_i (step_done),
    .avail_i     (avail_o),
    .timer_hold_o(timer_hold),
    .scl_pull_o  (scl_pull_o),
    .sda_pull_o  (sda_pull_o),
    .pin_own_o   (pin_own_o),
    .ctrl_rst_o  (ctrl_rst_o),
    .done_o      (done_o),
    .fail_o      (fail_o)
  );
endmodule

// File: rtl/i2c_bus_unjam_chk.sv
module i2c_bus_unjam_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_pull_o,
  input logic sda_pull_o,
  input logic pin_own_o,
  input logic ctrl_rst_o,
  input logic done_o
);
  p_pull_only_owned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_own_o |-> (!scl_pull_o && !sda_pull_o));
  p_rst_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_o |=> !ctrl_rst_o);
  p_rst_not_owned_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_o |-> !pin_own_o);
  p_rst_after_own_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_own_o) |-> ctrl_rst_o);
  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_not_owned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!pin_own_o && !ctrl_rst_o));
  p_own_start_released_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_own_o) |-> (!scl_pull_o && !sda_pull_o));
endmodule

bind i2c_bus_unjam i2c_bus_unjam_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_pull_o(scl_pull_o),
  .sda_pull_o(sda_pull_o),
  .pin_own_o (pin_own_o),
  .ctrl_rst_o(ctrl_rst_o),
  .done_o    (done_o)
);

// File: tb/i2c_bus_unjam_tb.sv
module i2c_bus_unjam_tb;
  localparam int DLY_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recover = 1'b0;
  logic [DLY_W-1:0] half_period = 16'd3;
  logic busy = 1'b0;
  logic scl_ext = 1'b1, sda_ext = 1'b1, sda_hold = 1'b0;
  logic scl_line, sda_line;
  logic scl_pull, sda_pull, pin_own, ctrl_rst, done, fail, avail;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  assign scl_line = pin_own ? !scl_pull : scl_ext;
  assign sda_line = (pin_own ? !sda_pull : sda_ext) & !sda_hold;

  i2c_bus_unjam #(.DLY_W(DLY_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .recover_i(recover), .half_period_i(half_period),
    .bus_busy_i(busy), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .pin_own_o(pin_own),
    .ctrl_rst_o(ctrl_rst), .done_o(done), .fail_o(fail), .avail_o(avail)
  );

  // monitor, samples at negedge
  logic mon_en = 1'b0;
  int cyc = 0, own_cyc, scl_rel, starts, stops, stop_after, rst_cnt, done_cnt;
  int rst_idx, done_idx, first_bad, release_after;
  logic p_own = 1'b0, p_scl = 1'b0, p_sda = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (pin_own) own_cyc++;
      if (pin_own && !p_own && (scl_pull || sda_pull)) first_bad++;
      if (pin_own && p_own) begin
        if (p_scl && !scl_pull) begin
          scl_rel++;
          if (release_after > 0 && scl_rel >= release_after) sda_hold = 1'b0;
        end
        if (!p_scl && !scl_pull && !p_sda && sda_pull) starts++;
        if (!p_scl && !scl_pull && p_sda && !sda_pull) begin
          stops++;
          stop_after = scl_rel;
        end
      end
      if (ctrl_rst) begin rst_cnt++; rst_idx = cyc; end
      if (done) begin done_cnt++; done_idx = cyc; end
    end
    p_own = pin_own; p_scl = scl_pull; p_sda = sda_pull;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input int n, input logic stuck, input int rel_after,
                         input logic extra_req, input logic exp_fail, input string tag);
    int steps;
    steps = (n == 0) ? 1 : n;
    half_period = DLY_W'(n);
    own_cyc = 0; scl_rel = 0; starts = 0; stops = 0; stop_after = -1;
    rst_cnt = 0; done_cnt = 0; rst_idx = 0; done_idx = 0; first_bad = 0;
    release_after = rel_after;
    sda_hold = stuck;
    @(negedge clk);
    mon_en = 1'b1;
    recover = 1'b1;
    @(negedge clk);
    recover = 1'b0;
    if (extra_req) begin
      repeat (5 * steps) @(negedge clk);
      recover = 1'b1;
      @(negedge clk);
      recover = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (4 * steps + 10) @(negedge clk);
    mon_en = 1'b0;
    check({"R3 first interval released ", tag}, first_bad, 0);
    check({"R3 start count ", tag}, starts, 1);
    check({"R4 scl releases ", tag}, scl_rel, 10);
    check({"R5 stop count ", tag}, stops, 1);
    check({"R5 stop after tenth release ", tag}, stop_after, 10);
    check({"R6 own cycles ", tag}, own_cyc, 24 * steps);
    check({"R7 ctrl reset count ", tag}, rst_cnt, 1);
    check({"R8 done count ", tag}, done_cnt, 1);
    check({"R8 done delay ", tag}, done_idx - rst_idx, steps + 1);
    check({"R8 fail flag ", tag}, int'(fail), int'(exp_fail));
    check({"R2 idle after run ", tag}, int'({pin_own, scl_pull, sda_pull, ctrl_rst, done}), 0);
    sda_hold = 1'b0;
  endtask

  task automatic test_reset;
    check("R2 reset outputs", int'({pin_own, scl_pull, sda_pull, ctrl_rst, done, fail}), 0);
    check("R1 reset avail", int'(avail), 1);
  endtask

  task automatic test_avail;
    busy = 1'b1; @(negedge clk);
    check("R1 busy blocks avail", int'(avail), 0);
    busy = 1'b0; @(negedge clk);
    check("R1 busy cleared", int'(avail), 1);
    sda_ext = 1'b0; @(negedge clk);
    check("R1 sync delay sda", int'(avail), 1);
    repeat (2) @(negedge clk);
    check("R1 sda low", int'(avail), 0);
    sda_ext = 1'b1; scl_ext = 1'b0; repeat (3) @(negedge clk);
    check("R1 scl low", int'(avail), 0);
    scl_ext = 1'b1; repeat (3) @(negedge clk);
    check("R1 lines back high", int'(avail), 1);
  endtask

  task automatic test_fail_clear;
    // fail from previous stuck run must clear once a new run begins
    @(negedge clk);
    recover = 1'b1;
    @(negedge clk);
    recover = 1'b0;
    check("R8 fail cleared at new start", int'(fail), 0);
    while (!done) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    test_avail();
    run_seq(3, 1'b1, 2, 1'b0, 1'b0, "n3 released");
    run_seq(1, 1'b0, 0, 1'b0, 1'b0, "n1");
    run_seq(0, 1'b0, 0, 1'b0, 1'b0, "n0 clamp");
    run_seq(5, 1'b1, 0, 1'b0, 1'b1, "n5 stuck");
    test_fail_clear();
    run_seq(4, 1'b0, 0, 1'b1, 1'b0, "R9 extra request");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule